// File: doc/BRIEF.md
# UART Autobaud Boot Receiver

This block sits on the serial line a boot loader uses after reset. It does not know the host's bit rate in advance. It waits for the sync character 0xAA and times the edges of that character in system clocks to find the bit period. It checks the stop bit of the sync frame, then answers on its transmit line with the two ASCII characters "OK" at the measured rate.

From then on it raises its lock flag and receives every further byte at the measured rate. Each byte goes to the downstream loader as a data byte with a one-cycle valid strobe. There is no further handshake. Frames that lack their stop bit are dropped and recorded in a sticky framing-error flag.

Serial frames are 8N1: one low start bit, eight data bits sent LSB first, no parity bit, and one high stop bit. The line idles high.

Top module: `uab_boot_rx`

## Requirements
- R1: While reset is held and just after it is released, txd_o is high and locked_o, valid_o and frame_err_o are low.
- R2: The bit period is the number of clocks from the falling edge of the 0xAA start bit to the fourth rising edge (the start of data bit 7), divided by 8. Every later transmitted and received bit lasts exactly that many clocks.
- R3: A sync measurement whose period comes out below MIN_PERIOD clocks (default 8) is discarded. The block stays unlocked, sends nothing, and waits for a new sync character.
- R4: If the line is low at the middle of the sync frame's stop bit, the measurement is discarded and restarted. No reply is sent.
- R5: After a valid sync, txd_o carries 0x4F ("O") and then 0x4B ("K") as 8N1 frames, LSB first, with a low start bit and a high stop bit. The line idles high before, between and after them.
- R6: locked_o stays low until the stop bit of "K" has been sent, then goes high and stays high until reset.
- R7: Once locked, each 8N1 frame with a high stop bit is delivered as data_o, LSB first and sampled at mid-bit, with valid_o high for exactly one clock.
- R8: valid_o never rises while locked_o is low, whatever is sent on rxd_i before lock.
- R9: Once locked, a frame whose stop bit is low is not delivered, and frame_err_o goes high and stays high until reset. Later good frames are still delivered.
- R10: Once locked, a low pulse on rxd_i that returns high before the middle of the start bit is ignored and delivers no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rxd_i | input | 1 | Serial receive line, asynchronous to clk, idles high |
| txd_o | output | 1 | Serial transmit line, idles high |
| data_o | output | 8 | Last received byte |
| valid_o | output | 1 | One-cycle strobe that data_o holds a new byte |
| locked_o | output | 1 | Bit rate measured and acknowledge sent |
| frame_err_o | output | 1 | Sticky flag: a frame after lock had a low stop bit |

## Verification
The assertions assume that rxd_i changes no faster than the two-flop synchronizer can follow. They also assume the host sends nothing while the acknowledge is being transmitted, so the transmitter is only started when it is idle. The bench holds every rxd_i level for a whole number of clocks, changes it only on the falling clock edge, and waits for "OK" before sending boot bytes. Its bit periods are multiples of whole clocks, so the measured period is exact. The rejected sync frames are sent at a rate too fast for MIN_PERIOD, or with a bad stop bit. In both cases the line returns to idle before the next frame starts.

// File: rtl/uab_pkg.sv
package uab_pkg;

  localparam logic [7:0] ACK_FIRST  = 8'h4F;
  localparam logic [7:0] ACK_SECOND = 8'h4B;
  localparam int unsigned SYNC_RISES = 4;

  typedef enum logic [1:0] {
    SEQ_SYNC,
    SEQ_ACK_O,
    SEQ_ACK_K,
    SEQ_RUN
  } seq_state_t;

  typedef enum logic [1:0] {
    MTR_IDLE,
    MTR_COUNT,
    MTR_STOP,
    MTR_DONE
  } mtr_state_t;

  typedef enum logic [1:0] {
    RCV_IDLE,
    RCV_START,
    RCV_DATA,
    RCV_STOP
  } rcv_state_t;

endpackage

// File: rtl/uab_meter.sv
module uab_meter
  import uab_pkg::*;
#(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned MIN_PERIOD = 8,
  localparam int unsigned PER_W     = CNT_W - 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             line_i,
  input  logic             fall_i,
  input  logic             rise_i,
  output logic             done_o,
  output logic [PER_W-1:0] period_o
);

  localparam int unsigned RISE_W = $clog2(SYNC_RISES + 1);

  mtr_state_t        state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [CNT_W-1:0]  timer_q, timer_n;
  logic [RISE_W-1:0] rises_q, rises_n;
  logic [PER_W-1:0]  period_q, period_n;
  logic              done_q, done_n;
  logic [PER_W-1:0]  cand;

  assign cand = cnt_q[CNT_W-1:3];

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    timer_n  = timer_q;
    rises_n  = rises_q;
    period_n = period_q;
    done_n   = 1'b0;
    unique case (state_q)
      MTR_IDLE: begin
        if (en_i && fall_i) begin
          cnt_n   = CNT_W'(1);
          rises_n = '0;
          state_n = MTR_COUNT;
        end
      end
      MTR_COUNT: begin
        cnt_n = cnt_q + CNT_W'(1);
        if (!en_i || (cnt_q == {CNT_W{1'b1}})) begin
          state_n = MTR_IDLE;
        end else if (rise_i) begin
          rises_n = rises_q + RISE_W'(1);
          if (rises_q == RISE_W'(SYNC_RISES - 1)) begin
            if (cand < PER_W'(MIN_PERIOD)) begin
              state_n = MTR_IDLE;
            end else begin
              period_n = cand;
              timer_n  = CNT_W'(cand) + CNT_W'(cand >> 1) - CNT_W'(1);
              state_n  = MTR_STOP;
            end
          end
        end
      end
      MTR_STOP: begin
        if (!en_i) begin
          state_n = MTR_IDLE;
        end else if (timer_q == '0) begin
          if (line_i) begin
            done_n  = 1'b1;
            state_n = MTR_DONE;
          end else begin
            state_n = MTR_IDLE;
          end
        end else begin
          timer_n = timer_q - CNT_W'(1);
        end
      end
      MTR_DONE: begin
        if (!en_i) state_n = MTR_IDLE;
      end
      default: state_n = MTR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= MTR_IDLE;
      cnt_q    <= '0;
      timer_q  <= '0;
      rises_q  <= '0;
      period_q <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_n;
      cnt_q    <= cnt_n;
      timer_q  <= timer_n;
      rises_q  <= rises_n;
      period_q <= period_n;
      done_q   <= done_n;
    end
  end

  assign done_o   = done_q;
  assign period_o = period_q;

  // R3: an accepted measurement never reports a period below the minimum
  a_r3_min_period: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (period_o >= PER_W'(MIN_PERIOD)));

  // R4: completion only follows a high line at the stop-bit sample point
  a_r4_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(line_i));

endmodule

// File: rtl/uab_rx.sv
module uab_rx
  import uab_pkg::*;
#(
  parameter int unsigned PER_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             line_i,
  input  logic             fall_i,
  input  logic [PER_W-1:0] period_i,
  output logic [7:0]       data_o,
  output logic             valid_o,
  output logic             ferr_o
);

  rcv_state_t       state_q, state_n;
  logic [PER_W-1:0] timer_q, timer_n;
  logic [2:0]       bit_q, bit_n;
  logic [7:0]       sh_q, sh_n;
  logic             valid_q, valid_n;
  logic             ferr_q, ferr_n;

  always_comb begin
    state_n = state_q;
    timer_n = timer_q;
    bit_n   = bit_q;
    sh_n    = sh_q;
    valid_n = 1'b0;
    ferr_n  = 1'b0;
    unique case (state_q)
      RCV_IDLE: begin
        if (en_i && fall_i) begin
          timer_n = (period_i >> 1) - PER_W'(1);
          state_n = RCV_START;
        end
      end
      RCV_START: begin
        if (timer_q == '0) begin
          if (!line_i) begin
            timer_n = period_i - PER_W'(1);
            bit_n   = '0;
            state_n = RCV_DATA;
          end else begin
            state_n = RCV_IDLE;
          end
        end else begin
          timer_n = timer_q - PER_W'(1);
        end
      end
      RCV_DATA: begin
        if (timer_q == '0) begin
          sh_n    = {line_i, sh_q[7:1]};
          timer_n = period_i - PER_W'(1);
          if (bit_q == 3'd7) state_n = RCV_STOP;
          else               bit_n   = bit_q + 3'd1;
        end else begin
          timer_n = timer_q - PER_W'(1);
        end
      end
      RCV_STOP: begin
        if (timer_q == '0) begin
          if (line_i) valid_n = 1'b1;
          else        ferr_n  = 1'b1;
          state_n = RCV_IDLE;
        end else begin
          timer_n = timer_q - PER_W'(1);
        end
      end
      default: state_n = RCV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RCV_IDLE;
      timer_q <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      timer_q <= timer_n;
      bit_q   <= bit_n;
      sh_q    <= sh_n;
      valid_q <= valid_n;
      ferr_q  <= ferr_n;
    end
  end

  assign data_o  = sh_q;
  assign valid_o = valid_q;
  assign ferr_o  = ferr_q;

  // R7: each delivered byte is a single-cycle strobe
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R9: a frame is either delivered or flagged, never both
  a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && ferr_o));

endmodule

// File: rtl/uab_tx.sv
module uab_tx #(
  parameter int unsigned PER_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [7:0]       data_i,
  input  logic [PER_W-1:0] period_i,
  output logic             txd_o,
  output logic             busy_o,
  output logic             done_o
);

  logic [9:0]       sh_q, sh_n;
  logic [3:0]       left_q, left_n;
  logic [PER_W-1:0] timer_q, timer_n;
  logic             busy_q, busy_n;
  logic             done_q, done_n;

  always_comb begin
    sh_n    = sh_q;
    left_n  = left_q;
    timer_n = timer_q;
    busy_n  = busy_q;
    done_n  = 1'b0;
    if (!busy_q) begin
      if (go_i) begin
        sh_n    = {1'b1, data_i, 1'b0};
        left_n  = 4'd10;
        timer_n = period_i - PER_W'(1);
        busy_n  = 1'b1;
      end
    end else if (timer_q == '0) begin
      sh_n    = {1'b1, sh_q[9:1]};
      timer_n = period_i - PER_W'(1);
      left_n  = left_q - 4'd1;
      if (left_q == 4'd1) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end else begin
      timer_n = timer_q - PER_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '1;
      left_q  <= '0;
      timer_q <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      sh_q    <= sh_n;
      left_q  <= left_n;
      timer_q <= timer_n;
      busy_q  <= busy_n;
      done_q  <= done_n;
    end
  end

  assign txd_o  = sh_q[0];
  assign busy_o = busy_q;
  assign done_o = done_q;

  // R5: the line idles high whenever no frame is in flight
  a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> txd_o);

  // R5: a new frame is only requested while the transmitter is idle
  a_r5_go_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !busy_o);

endmodule

// File: rtl/uab_boot_rx.sv
module uab_boot_rx
  import uab_pkg::*;
#(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned MIN_PERIOD = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd_i,
  output logic       txd_o,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       locked_o,
  output logic       frame_err_o
);

  localparam int unsigned PER_W = CNT_W - 3;

  logic [1:0]       rst_pipe;
  logic             rst_ni;
  logic [2:0]       rx_pipe;
  logic             line, fall, rise;
  seq_state_t       seq_q, seq_n;
  logic             ferr_q, ferr_n;
  logic             mtr_done;
  logic [PER_W-1:0] period;
  logic             tx_go, tx_busy, tx_done;
  logic [7:0]       tx_data;
  logic             rx_valid, rx_ferr;
  logic [7:0]       rx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rx_pipe <= '1;
    else         rx_pipe <= {rx_pipe[1:0], rxd_i};
  end
  assign line = rx_pipe[1];
  assign fall = rx_pipe[2] & ~rx_pipe[1];
  assign rise = ~rx_pipe[2] & rx_pipe[1];

  uab_meter #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) u_meter (
    .clk      (clk),
    .rst_n    (rst_ni),
    .en_i     (seq_q == SEQ_SYNC),
    .line_i   (line),
    .fall_i   (fall),
    .rise_i   (rise),
    .done_o   (mtr_done),
    .period_o (period)
  );

  always_comb begin
    seq_n   = seq_q;
    tx_go   = 1'b0;
    tx_data = ACK_FIRST;
    ferr_n  = ferr_q;
    unique case (seq_q)
      SEQ_SYNC: begin
        if (mtr_done) begin
          tx_go = 1'b1;
          seq_n = SEQ_ACK_O;
        end
      end
      SEQ_ACK_O: begin
        if (tx_done) begin
          tx_go   = 1'b1;
          tx_data = ACK_SECOND;
          seq_n   = SEQ_ACK_K;
        end
      end
      SEQ_ACK_K: begin
        if (tx_done) seq_n = SEQ_RUN;
      end
      SEQ_RUN: begin
        if (rx_ferr) ferr_n = 1'b1;
      end
      default: seq_n = SEQ_SYNC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q  <= SEQ_SYNC;
      ferr_q <= 1'b0;
    end else begin
      seq_q  <= seq_n;
      ferr_q <= ferr_n;
    end
  end

  uab_tx #(.PER_W(PER_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_ni),
    .go_i     (tx_go),
    .data_i   (tx_data),
    .period_i (period),
    .txd_o    (txd_o),
    .busy_o   (tx_busy),
    .done_o   (tx_done)
  );

  uab_rx #(.PER_W(PER_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_ni),
    .en_i     (seq_q == SEQ_RUN),
    .line_i   (line),
    .fall_i   (fall),
    .period_i (period),
    .data_o   (rx_data),
    .valid_o  (rx_valid),
    .ferr_o   (rx_ferr)
  );

  assign data_o      = rx_data;
  assign valid_o     = rx_valid;
  assign locked_o    = (seq_q == SEQ_RUN);
  assign frame_err_o = ferr_q;

  // R6: lock is never lost before reset
  a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_ni)
    locked_o |=> locked_o);

  // R6: lock only follows the end of the second acknowledge frame
  a_r6_lock_after_ack: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(tx_done));

  // R8: no byte is delivered before lock
  a_r8_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_ni)
    !locked_o |-> !valid_o);

  // R9: the framing-error flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    frame_err_o |=> frame_err_o);

endmodule

// File: tb/tb_uab_boot_rx.sv
module tb_uab_boot_rx;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       rxd;
  logic       txd;
  logic [7:0] data;
  logic       valid;
  logic       locked;
  logic       ferr;

  int checks;
  int errors;
  int bit_clks;
  int tx_frames;
  bit finished;

  logic [7:0] exp_q[$];
  logic [7:0] txq[$];

  uab_boot_rx dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .rxd_i       (rxd),
    .txd_o       (txd),
    .data_o      (data),
    .valid_o     (valid),
    .locked_o    (locked),
    .frame_err_o (ferr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rxd   = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic drive_frame(input logic [7:0] d, input bit stop_ok, input int bt);
    rxd = 1'b0;
    repeat (bt) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (bt) @(negedge clk);
    end
    rxd = stop_ok;
    repeat (bt) @(negedge clk);
    rxd = 1'b1;
    repeat (bt) @(negedge clk);
  endtask

  task automatic send_data(input logic [7:0] d, input bit stop_ok);
    if (stop_ok) exp_q.push_back(d);
    drive_frame(d, stop_ok, bit_clks);
  endtask

  task automatic sync_and_ack();
    int base;
    base = tx_frames;
    txq.push_back(8'h4F);
    txq.push_back(8'h4B);
    drive_frame(8'hAA, 1'b1, bit_clks);
    for (int i = 0; i < 20000 && tx_frames < base + 1; i++) @(negedge clk);
    check(locked == 1'b0, "R6 unlocked during ack", int'(locked), 0);
    for (int i = 0; i < 20000 && tx_frames < base + 2; i++) @(negedge clk);
    repeat (bit_clks + 4) @(negedge clk);
    check(locked == 1'b1, "R6 locked after ack", int'(locked), 1);
  endtask

  // scoreboard monitor for delivered bytes (R7, R8)
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8/R10 unexpected byte", int'(data), -1);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(data == e, "R7 byte", int'(data), int'(e));
      end
    end
  end

  // scoreboard monitor for transmitted frames (R2, R5)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        int w;
        logic [7:0] b;
        logic [7:0] e;
        w = 1;
        @(negedge clk);
        while (txd === 1'b0 && w < 5000) begin
          w++;
          @(negedge clk);
        end
        check(w == bit_clks, "R2 start bit width", w, bit_clks);
        repeat (bit_clks / 2 - 1) @(negedge clk);
        b[0] = txd;
        for (int i = 1; i < 8; i++) begin
          repeat (bit_clks) @(negedge clk);
          b[i] = txd;
        end
        repeat (bit_clks) @(negedge clk);
        check(txd === 1'b1, "R5 stop bit", int'(txd), 1);
        tx_frames++;
        if (txq.size() == 0) begin
          check(1'b0, "R3/R4 unexpected reply", int'(b), -1);
        end else begin
          e = txq.pop_front();
          check(b == e, "R5 ack char", int'(b), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks    = 0;
    errors    = 0;
    tx_frames = 0;
    finished  = 1'b0;
    bit_clks  = 40;
    rst_n = 1'b0;
    rxd   = 1'b1;
    repeat (3) @(negedge clk);
    check(txd == 1'b1 && locked == 1'b0 && valid == 1'b0 && ferr == 1'b0,
          "R1 in reset", int'({txd, locked, valid, ferr}), 8);
    do_reset();
    check(txd == 1'b1 && locked == 1'b0 && valid == 1'b0 && ferr == 1'b0,
          "R1 after reset", int'({txd, locked, valid, ferr}), 8);

    // R3: sync at 2 clocks per bit is noise
    drive_frame(8'hAA, 1'b1, 2);
    repeat (300) @(negedge clk);
    check(locked == 1'b0, "R3 locked", int'(locked), 0);
    check(tx_frames == 0, "R3 reply frames", tx_frames, 0);

    // R4: sync with a low stop bit is rejected
    drive_frame(8'hAA, 1'b0, bit_clks);
    repeat (400) @(negedge clk);
    check(locked == 1'b0, "R4 locked", int'(locked), 0);
    check(tx_frames == 0, "R4 reply frames", tx_frames, 0);

    // R2 R5 R6: real sync
    sync_and_ack();

    // R7: varied data patterns
    send_data(8'h00, 1'b1);
    send_data(8'hFF, 1'b1);
    send_data(8'h5A, 1'b1);
    send_data(8'hA5, 1'b1);
    send_data(8'h01, 1'b1);
    send_data(8'h80, 1'b1);

    // R10: short low glitch is ignored
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * bit_clks) @(negedge clk);
    check(exp_q.size() == 0, "R10 no byte from glitch", exp_q.size(), 0);
    send_data(8'h3C, 1'b1);

    // R9: low stop bit after lock
    check(ferr == 1'b0, "R9 flag before error", int'(ferr), 0);
    send_data(8'h77, 1'b0);
    check(ferr == 1'b1, "R9 flag after error", int'(ferr), 1);
    send_data(8'hC3, 1'b1);
    check(ferr == 1'b1, "R9 flag sticky", int'(ferr), 1);
    check(locked == 1'b1, "R6 lock held", int'(locked), 1);

    // R2: second rate after reset
    do_reset();
    check(locked == 1'b0 && ferr == 1'b0, "R1 second reset",
          int'({locked, ferr}), 0);
    bit_clks = 24;
    sync_and_ack();
    send_data(8'h12, 1'b1);
    send_data(8'hED, 1'b1);

    // R2: third rate
    do_reset();
    bit_clks = 57;
    sync_and_ack();
    send_data(8'h96, 1'b1);
    send_data(8'h69, 1'b1);

    repeat (200) @(negedge clk);
    check(exp_q.size() == 0, "R7 all bytes delivered", exp_q.size(), 0);
    check(txq.size() == 0, "R5 all acks sent", txq.size(), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule